// File: doc/BRIEF.md
# Two-Level Interrupt Status Collector with Read-Clear and Fault Auto-Disable

This block collects event inputs from five source status registers, split between a receive section and a transmit section. It sets sticky status bits, summarises them per section in a block-level status register, and drives a single active-low interrupt request. A host finds the interrupting section by reading the summary register. It then reads that section's source status registers, and each read clears the bits it returns.

A condition that is still present after its bit has been cleared sets the bit again. A lasting fault would therefore keep the host in an endless service loop. An optional hardware guard counts fast re-firings of each bit and clears that bit's enable after a set number of them in a row. Software re-arms the bit by writing its enable.

Host access is synchronous, using address, read strobe, write strobe and write data. Read data appears one cycle after the strobe. The `mode_sel` input chooses between two fixed maps of source addresses.

Top module: `irq_hier_ctrl`

## Requirements
- R1: After reset all status bits, enable bits and the auto-disable control bit are 0, every register reads 0 and `irq_n` is 1.
- R2: A status bit sets when its enable bit is 1 and its event input rises. An event on a bit whose enable is 0 leaves the status bit at 0.
- R3: A read of a source status register returns the value it held before the read, in `rdata` one cycle after the read strobe. The same read clears every set bit of that register.
- R4: If a bit's event rises in the same cycle as a clearing read of its register, the bit stays set after the read.
- R5: The summary register at 0x10 holds bit 0 = receive section pending and bit 1 = transmit section pending. A section is pending when any status bit ANDed with its enable bit is 1 in that section. The section bit drops when the last such bit is cleared.
- R6: `irq_n` is 0 exactly while at least one summary bit is 1.
- R7: If an enabled event input is still high after its bit was cleared by a read, the bit sets again one cycle after the clearing read, and `irq_n` goes low again.
- R8: Each source's enable register sits at its status address plus 0x40. It is read/write. Writes to status registers have no effect.
- R9: When `mode_sel` = 0, the receive sources are at 0x13, 0x17 and 0x18 and the transmit sources are at 0x31 and 0x34. When `mode_sel` = 1, the receive sources are at 0x14, 0x15 and 0x18 and the transmit source is at 0x34. In mode 1 the 0x31 source is absent: its events are ignored and unmapped addresses read 0.
- R10: Bit 0 of the control register at 0x11 enables auto-disable. While it is 1, a bit that re-sets within WIN_CYC cycles of being cleared, RETRIP times in a row, has its enable bit cleared by hardware. A re-set outside the window restarts the count. Writing the enable register re-arms the bit and restarts its count.
- R11: While auto-disable is 0, hardware never clears an enable bit, however often a bit re-fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | Address map select (0 or 1) |
| evt_i | input | 5*SRC_W | Event inputs, source s at bits [s*SRC_W +: SRC_W] |
| addr | input | 7 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | SRC_W | Write data |
| rdata | output | SRC_W | Read data, valid one cycle after the strobe |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with SRC_W = 8, WIN_CYC = 8 and RETRIP = 3. The short window lets the bench reach both sides of the re-fire window with an idle gap of only 12 cycles. It can therefore show that a slow repeat never trips the guard, while three back-to-back re-firings of a held event do. Eight-bit sources let the bench place a same-cycle event on one bit while another bit of the same register is being cleared.

// File: rtl/irq_hier_pkg.sv
// Package: address map, section assignment and shared constants for the
// two-level interrupt collector. Assumes five source slots in a fixed map.
package irq_hier_pkg;

    localparam int NUM_SRC = 5;
    localparam int NUM_SEC = 2;
    localparam int ADDR_W  = 7;

    localparam logic [ADDR_W-1:0] SUMMARY_ADDR = 7'h10;
    localparam logic [ADDR_W-1:0] CTRL_ADDR    = 7'h11;
    localparam logic [ADDR_W-1:0] EN_OFFSET    = 7'h40;

    typedef enum logic {SEC_RX = 1'b0, SEC_TX = 1'b1} section_e;

    // Status address of a slot under the selected map.
    function automatic logic [ADDR_W-1:0] stat_addr(input int s, input logic m);
        logic [ADDR_W-1:0] a;
        case (s)
            0:       a = m ? 7'h14 : 7'h13;
            1:       a = m ? 7'h15 : 7'h17;
            2:       a = 7'h18;
            3:       a = m ? 7'h00 : 7'h31;
            default: a = 7'h34;
        endcase
        return a;
    endfunction

    // Whether a slot exists under the selected map.
    function automatic logic slot_present(input int s, input logic m);
        return !(m && (s == 3));
    endfunction

    // Section that a slot reports into.
    function automatic section_e slot_section(input int s);
        return (s < 3) ? SEC_RX : SEC_TX;
    endfunction

endpackage

// File: rtl/irq_trip_cell.sv
// Re-fire guard for one status bit: opens a window of WIN_CYC cycles when
// the bit is cleared, counts consecutive re-sets inside the window, and
// flags a trip on the RETRIP-th one when auto-disable is on.
// Assumes 'refire' and 'cleared' never both assert for one bit.
module irq_trip_cell #(
    parameter int WIN_CYC = 16,
    parameter int RETRIP  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic rearm,
    input  logic cleared,
    input  logic refire,
    output logic trip
);
    localparam int CNT_W = $clog2(WIN_CYC + 1);
    localparam int STK_W = $clog2(RETRIP + 1);
    localparam logic [STK_W-1:0] STK_LAST = STK_W'(RETRIP - 1);

    logic [CNT_W-1:0] win_q;
    logic [STK_W-1:0] stk_q;
    logic             win_open;

    assign win_open = (win_q != '0);
    assign trip     = auto_en && refire && win_open && (stk_q == STK_LAST);

    // Window countdown, reloaded on every clear of the bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_q <= '0;
        else if (cleared)
            win_q <= CNT_W'(WIN_CYC);
        else if (win_open)
            win_q <= win_q - 1'b1;
    end

    // Consecutive fast re-fire count, saturating one short of a trip.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stk_q <= '0;
        else if (rearm)
            stk_q <= '0;
        else if (refire) begin
            if (!win_open || trip)
                stk_q <= '0;
            else if (stk_q != STK_LAST)
                stk_q <= stk_q + 1'b1;
        end
    end

endmodule

// File: rtl/irq_src_reg.sv
// One source slot: sticky status bits, enable bits, clear-on-read and the
// per-bit re-fire guards. A bit sets on a rising event, or when its event
// is still high in the cycle after a read cleared it.
module irq_src_reg #(
    parameter int SRC_W   = 8,
    parameter int WIN_CYC = 16,
    parameter int RETRIP  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             present,
    input  logic             auto_en,
    input  logic [SRC_W-1:0] evt,
    input  logic             rd_clr,
    input  logic             en_wr,
    input  logic [SRC_W-1:0] wdata,
    output logic [SRC_W-1:0] status,
    output logic [SRC_W-1:0] enable,
    output logic             pending
);
    logic [SRC_W-1:0] evt_q, rearm_q, rise, set_v, clr_v, refire_v, trip_v;

    assign rise     = evt & ~evt_q;
    assign set_v    = {SRC_W{present}} & enable & evt & (rise | rearm_q);
    assign clr_v    = {SRC_W{rd_clr}} & status & ~set_v;
    assign refire_v = set_v & ~status;
    assign pending  = present && (|(status & enable));

    // Event history for edge detection and post-clear re-arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q   <= '0;
            rearm_q <= '0;
        end else begin
            evt_q   <= evt;
            rearm_q <= clr_v;
        end
    end

    // Sticky status: read clears, a same-cycle set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= (status & ~{SRC_W{rd_clr}}) | set_v;
    end

    // Enable bits: software write wins over hardware auto-disable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable <= '0;
        else if (en_wr)
            enable <= wdata;
        else
            enable <= enable & ~trip_v;
    end

    for (genvar b = 0; b < SRC_W; b++) begin : g_bit
        irq_trip_cell #(
            .WIN_CYC (WIN_CYC),
            .RETRIP  (RETRIP)
        ) trip_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .auto_en (auto_en),
            .rearm   (en_wr),
            .cleared (clr_v[b]),
            .refire  (refire_v[b]),
            .trip    (trip_v[b])
        );
    end

endmodule

// File: rtl/irq_host_if.sv
// Host register port: decodes the mode-dependent address map, issues
// clear and enable-write strobes to slots, holds the auto-disable control
// bit and registers read data one cycle after the read strobe.
module irq_host_if
    import irq_hier_pkg::*;
#(
    parameter int SRC_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            mode_sel,
    input  logic [ADDR_W-1:0]               addr,
    input  logic                            rd_en,
    input  logic                            wr_en,
    input  logic [SRC_W-1:0]                wdata,
    input  logic [NUM_SRC-1:0][SRC_W-1:0]   stat_arr,
    input  logic [NUM_SRC-1:0][SRC_W-1:0]   en_arr,
    input  logic [NUM_SEC-1:0]              summary,
    output logic [NUM_SRC-1:0]              rd_clr,
    output logic [NUM_SRC-1:0]              en_wr,
    output logic                            auto_en,
    output logic [SRC_W-1:0]                rdata
);
    logic [SRC_W-1:0] rd_val;

    // Address decode and read multiplexer.
    always_comb begin
        rd_val = '0;
        rd_clr = '0;
        en_wr  = '0;
        if (addr == SUMMARY_ADDR)
            rd_val = SRC_W'(summary);
        if (addr == CTRL_ADDR)
            rd_val = SRC_W'(auto_en);
        for (int s = 0; s < NUM_SRC; s++) begin
            if (slot_present(s, mode_sel)) begin
                if (addr == stat_addr(s, mode_sel)) begin
                    rd_val    = stat_arr[s];
                    rd_clr[s] = rd_en;
                end
                if (addr == (stat_addr(s, mode_sel) | EN_OFFSET)) begin
                    rd_val   = en_arr[s];
                    en_wr[s] = wr_en;
                end
            end
        end
    end

    // Auto-disable control bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            auto_en <= 1'b0;
        else if (wr_en && (addr == CTRL_ADDR))
            auto_en <= wdata[0];
    end

    // Registered read data, captured before the clear lands.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_val;
    end

endmodule

// File: rtl/irq_hier_ctrl.sv
// Top: five source slots, per-section summary and active-low request.
// Assumes SRC_W >= 2 so the summary register fits in read data.
module irq_hier_ctrl
    import irq_hier_pkg::*;
#(
    parameter int SRC_W   = 8,
    parameter int WIN_CYC = 16,
    parameter int RETRIP  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_sel,
    input  logic [NUM_SRC*SRC_W-1:0] evt_i,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     rd_en,
    input  logic                     wr_en,
    input  logic [SRC_W-1:0]         wdata,
    output logic [SRC_W-1:0]         rdata,
    output logic                     irq_n
);
    logic [NUM_SRC-1:0][SRC_W-1:0] stat_arr, en_arr;
    logic [NUM_SRC-1:0]            rd_clr, en_wr, pending;
    logic [NUM_SEC-1:0]            summary;
    logic                          auto_en;

    irq_host_if #(.SRC_W(SRC_W)) host_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .addr     (addr),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .stat_arr (stat_arr),
        .en_arr   (en_arr),
        .summary  (summary),
        .rd_clr   (rd_clr),
        .en_wr    (en_wr),
        .auto_en  (auto_en),
        .rdata    (rdata)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        irq_src_reg #(
            .SRC_W   (SRC_W),
            .WIN_CYC (WIN_CYC),
            .RETRIP  (RETRIP)
        ) src_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .present (slot_present(s, mode_sel)),
            .auto_en (auto_en),
            .evt     (evt_i[s*SRC_W +: SRC_W]),
            .rd_clr  (rd_clr[s]),
            .en_wr   (en_wr[s]),
            .wdata   (wdata),
            .status  (stat_arr[s]),
            .enable  (en_arr[s]),
            .pending (pending[s])
        );
    end

    // Per-section OR of pending slots.
    always_comb begin
        summary = '0;
        for (int s = 0; s < NUM_SRC; s++)
            if (pending[s])
                summary[int'(slot_section(s))] = 1'b1;
    end

    assign irq_n = ~(|summary);

endmodule

// File: rtl/irq_hier_ctrl_chk.sv
// Checker for irq_hier_ctrl: read-clear, pre-clear read data, enable
// writes, enable-gated set and auto-disable gating. Bound to the top.
module irq_hier_ctrl_chk
    import irq_hier_pkg::*;
#(
    parameter int SRC_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [SRC_W-1:0]              wdata,
    input logic                          auto_en,
    input logic [NUM_SRC-1:0]            rd_clr,
    input logic [NUM_SRC-1:0]            en_wr,
    input logic [NUM_SRC-1:0][SRC_W-1:0] stat_arr,
    input logic [NUM_SRC-1:0][SRC_W-1:0] en_arr,
    input logic [NUM_SRC*SRC_W-1:0]      evt_i,
    input logic [SRC_W-1:0]              rdata
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
        // R3
        read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_clr[s] |=> ((stat_arr[s] & $past(stat_arr[s])
                            & ~$past(evt_i[s*SRC_W +: SRC_W])) == '0));
        // R3
        pre_clear_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_clr[s] |=> (rdata == $past(stat_arr[s])));
        // R8
        enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            en_wr[s] |=> (en_arr[s] == $past(wdata)));
        // R2
        set_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((stat_arr[s] & ~$past(stat_arr[s]) & ~$past(en_arr[s])) == '0));
        // R11
        hw_disable_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !en_wr[s] && !auto_en |=> ((~en_arr[s] & $past(en_arr[s])) == '0));
    end
endmodule

bind irq_hier_ctrl irq_hier_ctrl_chk #(.SRC_W(SRC_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wdata    (wdata),
    .auto_en  (auto_en),
    .rd_clr   (rd_clr),
    .en_wr    (en_wr),
    .stat_arr (stat_arr),
    .en_arr   (en_arr),
    .evt_i    (evt_i),
    .rdata    (rdata)
);

// File: tb/irq_hier_ctrl_tb_top.sv
// Scoreboard bench: read tasks queue expected data, a monitor compares
// rdata one cycle after each read strobe; direct checks cover irq_n.
module irq_hier_ctrl_tb_top;
    localparam int SRC_W = 8;
    localparam int NSRC  = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_sel = 1'b0;
    logic [NSRC*SRC_W-1:0] evt_i = '0;
    logic [6:0]       addr = '0;
    logic             rd_en = 1'b0;
    logic             wr_en = 1'b0;
    logic [SRC_W-1:0] wdata = '0;
    logic [SRC_W-1:0] rdata;
    logic             irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    logic [SRC_W-1:0] exp_q[$];
    string            tag_q[$];
    logic             pend = 1'b0;

    always #5 clk = ~clk;

    irq_hier_ctrl #(.SRC_W(SRC_W), .WIN_CYC(8), .RETRIP(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .evt_i(evt_i),
        .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .irq_n(irq_n)
    );

    // Monitor: compares read data the cycle after each strobe.
    always @(negedge clk) begin
        if (pend) begin
            logic [SRC_W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (rdata !== e) begin
                n_bad++;
                $display("FAIL %s: rdata actual %02h expected %02h", t, rdata, e);
            end
        end
        pend = rd_en;
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic host_read(input logic [6:0] a, input logic [7:0] e, input string t);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        tick();
        rd_en = 1'b0;
    endtask

    task automatic host_write(input logic [6:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int idx);
        evt_i[idx] = 1'b1;
        tick();
        evt_i[idx] = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_cmp++;
        if (irq_n !== e) begin
            n_bad++;
            $display("FAIL %s: irq_n actual %0b expected %0b", t, irq_n, e);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk_irq(1'b1, "R1");
        host_read(7'h10, 8'h00, "R1");
        host_read(7'h53, 8'h00, "R1");
        host_read(7'h11, 8'h00, "R1");
        // R8 enable read/write
        host_write(7'h53, 8'hFF);
        host_read(7'h53, 8'hFF, "R8");
        // R2 / R3 / R5 / R6 basic service
        pulse(0*8+2);
        chk_irq(1'b0, "R6");
        host_read(7'h10, 8'h01, "R5");
        host_read(7'h13, 8'h04, "R3");
        host_read(7'h13, 8'h00, "R3");
        chk_irq(1'b1, "R6");
        host_read(7'h10, 8'h00, "R5");
        // R2 disabled event ignored
        pulse(1*8+0);
        chk_irq(1'b1, "R2");
        host_read(7'h17, 8'h00, "R2");
        // R8 status write ignored
        host_write(7'h13, 8'hFF);
        host_read(7'h13, 8'h00, "R8");
        // R5 transmit section
        host_write(7'h74, 8'h01);
        pulse(4*8+0);
        host_read(7'h10, 8'h02, "R5");
        host_read(7'h34, 8'h01, "R5");
        // R4 same-cycle event during clearing read
        host_write(7'h71, 8'h03);
        pulse(3*8+0);
        addr = 7'h31; rd_en = 1'b1; evt_i[3*8+1] = 1'b1;
        exp_q.push_back(8'h01); tag_q.push_back("R4");
        tick();
        rd_en = 1'b0; evt_i[3*8+1] = 1'b0;
        host_read(7'h31, 8'h02, "R4");
        chk_irq(1'b1, "R4");
        // R7 held event re-fires after clear, auto-disable off
        host_write(7'h58, 8'h01);
        evt_i[2*8+0] = 1'b1;
        tick();
        for (int i = 0; i < 4; i++) begin
            host_read(7'h18, 8'h01, "R7");
            chk_irq(1'b1, "R7");
            tick();
            chk_irq(1'b0, "R7");
        end
        host_read(7'h58, 8'h01, "R11");
        // R10 auto-disable after three fast re-fires
        host_write(7'h11, 8'h01);
        host_read(7'h11, 8'h01, "R10");
        host_write(7'h58, 8'h01);
        for (int i = 0; i < 3; i++) begin
            host_read(7'h18, 8'h01, "R10");
            tick();
            chk_irq((i == 2) ? 1'b1 : 1'b0, "R10");
        end
        host_read(7'h58, 8'h00, "R10");
        host_write(7'h58, 8'h01);
        chk_irq(1'b0, "R10");
        evt_i[2*8+0] = 1'b0;
        host_read(7'h18, 8'h01, "R10");
        chk_irq(1'b1, "R10");
        // R10 slow re-fires outside the window never trip
        repeat (12) tick();
        for (int i = 0; i < 3; i++) begin
            pulse(2*8+0);
            host_read(7'h18, 8'h01, "R10");
            repeat (12) tick();
        end
        host_read(7'h58, 8'h01, "R10");
        // R9 alternate address map
        mode_sel = 1'b1;
        tick();
        host_read(7'h54, 8'hFF, "R9");
        host_read(7'h53, 8'h00, "R9");
        pulse(0*8+1);
        host_read(7'h14, 8'h02, "R9");
        pulse(3*8+0);
        chk_irq(1'b1, "R9");
        host_read(7'h31, 8'h00, "R9");
        host_read(7'h10, 8'h00, "R9");
        repeat (3) tick();
        finish_run();
    end
endmodule